// File: doc/BRIEF.md
# Private/Shared Line Placement Controller

This block decides which bank of a banked last-level cache should hold each cache line. The cache has one private bank beside each core and one central bank kept for lines that several cores use. The controller stores only tags, locations and sharer sets, not line data. For each request (core number, line address) it reports which bank serves the access. When a line has to move, it also issues migration commands.

A line that only one core has touched stays in that core's private bank. When a second core reaches a line held in a private bank, the line is promoted to the central bank. If the central bank is full, one of its lines is pushed back to the private bank of one of its recorded sharers, so it is not lost. Each private bank has a fixed number of ways. Inserting into a full private bank drops the line that has been resident there longest, and that line leaves the cache. Requests are taken one at a time over a valid/ready handshake. All directory updates for one request are finished before the next request is accepted.

Top module: `line_placement_ctl`

## Requirements
- R1: After a synchronous active-low reset, reqReady is high, rspValid is low, and no line is resident anywhere, so the next access to any line is a first access (R2).
- R2: An access to a line that is not resident is served by the requesting core's own bank (bank code equal to the core number, 0..NUM_CORES-1), and no migration or demotion is reported.
- R3: An access by the core whose private bank holds the line is served by that bank, with no migration.
- R4: An access by any other core to a line held in a private bank is served by the central bank (bank code NUM_CORES). It reports rspMigrate=1 with rspMigSrc set to the old private bank and rspMigDst set to NUM_CORES.
- R5: An access to a line already in the central bank is served there with no migration, and the requester is added to that line's sharer set.
- R6: Promotions fill free central-bank slots lowest index first. When all slots are full, the victim slot is picked by a round-robin pointer. The pointer starts at slot 0 after reset, moves one slot per victim and wraps after slot SHARED_SLOTS-1. The new line takes the victim's slot.
- R7: A central-bank victim is demoted, not dropped. The response carries rspDemote=1 and rspDemoteDst set to the lowest-numbered core in the victim's sharer set, and the victim then lives in that core's private bank with that core as its only sharer.
- R8: Each private bank holds PRIV_WAYS lines. An insertion into a full private bank (from a miss or a demotion) removes the line that has been resident longest in that bank from the cache, so the next access to that line is a first access.
- R9: rspValid is high exactly in the cycle after a request is accepted. reqReady is low in that cycle, and the response fields are meaningful only while rspValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request |
| reqCore | input | $clog2(NUM_CORES) | Requesting core |
| reqLine | input | ADDR_W | Line address |
| rspValid | output | 1 | Response present |
| rspBank | output | $clog2(NUM_CORES+1) | Serving bank (NUM_CORES = central) |
| rspMigrate | output | 1 | Line moves from a private bank to the central bank |
| rspMigSrc | output | $clog2(NUM_CORES+1) | Migration source bank |
| rspMigDst | output | $clog2(NUM_CORES+1) | Migration destination bank |
| rspDemote | output | 1 | A central-bank victim moves to a private bank |
| rspDemoteDst | output | $clog2(NUM_CORES+1) | Private bank receiving the victim |

## Verification
The bench uses the default build: eight cores, two ways per private bank and four central-bank slots. With these sizes the central bank fills after four promotions and the round-robin pointer wraps within a few dozen requests. A private bank overflows on its third line, so eviction of the oldest line, including after a demotion into a full bank, can be driven by a short hand-traced sequence. The sequence also has a new low-numbered sharer join a central line before that line is victimized, which makes the sharer-set update visible in the demotion target.

// File: rtl/placement_pkg.sv
package placement_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } ctlState_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic latchReq;  // capture request fields this edge
    logic commit;    // apply directory update this edge, response is live
  } ctlStrobe_t;

endpackage

// File: rtl/placement_ctrl.sv
module placement_ctrl
  import placement_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       rspValid,
  output ctlStrobe_t strobe
);

  ctlState_e state;
  ctlState_e stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (reqValid) stateNxt = ST_EXEC;
      ST_EXEC: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign reqReady        = (state == ST_IDLE);
  assign rspValid        = (state == ST_EXEC);
  assign strobe.latchReq = reqValid && (state == ST_IDLE);
  assign strobe.commit   = (state == ST_EXEC);

endmodule

// File: rtl/placement_datapath.sv
module placement_datapath
  import placement_pkg::*;
#(
  parameter int NUM_CORES    = 8,
  parameter int PRIV_WAYS    = 2,
  parameter int SHARED_SLOTS = 4,
  parameter int ADDR_W       = 12
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctlStrobe_t                       strobe,
  input  logic [$clog2(NUM_CORES)-1:0]     reqCore,
  input  logic [ADDR_W-1:0]                reqLine,
  output logic [$clog2(NUM_CORES+1)-1:0]   rspBank,
  output logic                             rspMigrate,
  output logic [$clog2(NUM_CORES+1)-1:0]   rspMigSrc,
  output logic [$clog2(NUM_CORES+1)-1:0]   rspMigDst,
  output logic                             rspDemote,
  output logic [$clog2(NUM_CORES+1)-1:0]   rspDemoteDst
);

  localparam int CORE_W     = $clog2(NUM_CORES);
  localparam int BANK_W     = $clog2(NUM_CORES + 1);
  localparam int PRIV_SLOTS = NUM_CORES * PRIV_WAYS;
  localparam int PSLOT_W    = $clog2(PRIV_SLOTS);
  localparam int AGE_W      = $clog2(PRIV_WAYS);
  localparam int SH_W       = $clog2(SHARED_SLOTS);
  localparam logic [BANK_W-1:0] SHARED_CODE = BANK_W'(NUM_CORES);
  localparam logic [AGE_W-1:0]  AGE_OLDEST  = AGE_W'(PRIV_WAYS - 1);

  function automatic logic [CORE_W-1:0] lowestCore(input logic [NUM_CORES-1:0] m);
    logic [CORE_W-1:0] r;
    r = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) if (m[i]) r = CORE_W'(i);
    return r;
  endfunction

  function automatic logic [NUM_CORES-1:0] coreBit(input logic [CORE_W-1:0] c);
    logic [NUM_CORES-1:0] r;
    r = '0;
    r[c] = 1'b1;
    return r;
  endfunction

  // Latched request
  logic [CORE_W-1:0] curCore;
  logic [ADDR_W-1:0] curLine;

  // Private-bank directory (slot = bank * PRIV_WAYS + way)
  logic [PRIV_SLOTS-1:0] pValid, pValidNxt;
  logic [ADDR_W-1:0]     pTag   [PRIV_SLOTS];
  logic [ADDR_W-1:0]     pTagNxt[PRIV_SLOTS];
  logic [NUM_CORES-1:0]  pShr   [PRIV_SLOTS];
  logic [NUM_CORES-1:0]  pShrNxt[PRIV_SLOTS];
  logic [AGE_W-1:0]      pAge   [PRIV_SLOTS];
  logic [AGE_W-1:0]      pAgeNxt[PRIV_SLOTS];

  // Central-bank directory
  logic [SHARED_SLOTS-1:0] sValid, sValidNxt;
  logic [ADDR_W-1:0]       sTag   [SHARED_SLOTS];
  logic [ADDR_W-1:0]       sTagNxt[SHARED_SLOTS];
  logic [NUM_CORES-1:0]    sShr   [SHARED_SLOTS];
  logic [NUM_CORES-1:0]    sShrNxt[SHARED_SLOTS];
  logic [SH_W-1:0]         rrPtr, rrPtrNxt;

  // Lookup results
  logic                pHit;
  logic [PSLOT_W-1:0]  pHitSlot;
  logic [CORE_W-1:0]   pHitBank;
  logic                sHit;
  logic [SH_W-1:0]     sHitSlot;
  logic                sHasFree;
  logic [SH_W-1:0]     sFreeSlot;

  // Decisions
  logic                isShHit, isLocal, isPromote, isMiss, needDemote;
  logic [SH_W-1:0]     sTgt;
  logic [CORE_W-1:0]   demoteCore;
  logic [NUM_CORES-1:0] reqBit;

  // Private insertion / removal
  logic                insEn;
  logic [CORE_W-1:0]   insBank;
  logic [ADDR_W-1:0]   insTag;
  logic [PSLOT_W-1:0]  insSlot;
  logic                insHasFree;
  logic [PSLOT_W-1:0]  insFreeSlot;
  logic [PSLOT_W-1:0]  insOldSlot;
  logic                remEn;
  logic [AGE_W-1:0]    remAge;
  logic [PRIV_SLOTS-1:0] validAfter;

  // ---------------------------------------------------------------
  // Request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCore <= '0;
      curLine <= '0;
    end else if (strobe.latchReq) begin
      curCore <= reqCore;
      curLine <= reqLine;
    end
  end

  // ---------------------------------------------------------------
  // Tag search in both parts of the directory
  always_comb begin
    pHit     = 1'b0;
    pHitSlot = '0;
    pHitBank = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      for (int w = 0; w < PRIV_WAYS; w++) begin
        if (!pHit && pValid[k*PRIV_WAYS+w] && pTag[k*PRIV_WAYS+w] == curLine) begin
          pHit     = 1'b1;
          pHitSlot = PSLOT_W'(k*PRIV_WAYS+w);
          pHitBank = CORE_W'(k);
        end
      end
    end
  end

  always_comb begin
    sHit      = 1'b0;
    sHitSlot  = '0;
    sHasFree  = 1'b0;
    sFreeSlot = '0;
    for (int j = 0; j < SHARED_SLOTS; j++) begin
      if (!sHit && sValid[j] && sTag[j] == curLine) begin
        sHit     = 1'b1;
        sHitSlot = SH_W'(j);
      end
      if (!sHasFree && !sValid[j]) begin
        sHasFree  = 1'b1;
        sFreeSlot = SH_W'(j);
      end
    end
  end

  // ---------------------------------------------------------------
  // Placement decision
  always_comb begin
    reqBit     = coreBit(curCore);
    isShHit    = sHit;
    isLocal    = !sHit && pHit && (pHitBank == curCore);
    isPromote  = !sHit && pHit && (pHitBank != curCore);
    isMiss     = !sHit && !pHit;
    needDemote = isPromote && !sHasFree;
    sTgt       = sHasFree ? sFreeSlot : rrPtr;
    demoteCore = lowestCore(sShr[rrPtr]);

    insEn   = isMiss || needDemote;
    insBank = isMiss ? curCore : demoteCore;
    insTag  = isMiss ? curLine : sTag[rrPtr];

    remEn      = isPromote;
    remAge     = pAge[pHitSlot];
    validAfter = pValid;
    if (remEn) validAfter[pHitSlot] = 1'b0;
  end

  // Way choice inside the insertion bank: lowest free way, else oldest.
  always_comb begin
    insHasFree  = 1'b0;
    insFreeSlot = '0;
    insOldSlot  = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      for (int w = 0; w < PRIV_WAYS; w++) begin
        if (CORE_W'(k) == insBank) begin
          if (!insHasFree && !validAfter[k*PRIV_WAYS+w]) begin
            insHasFree  = 1'b1;
            insFreeSlot = PSLOT_W'(k*PRIV_WAYS+w);
          end
          if (validAfter[k*PRIV_WAYS+w] && pAge[k*PRIV_WAYS+w] == AGE_OLDEST)
            insOldSlot = PSLOT_W'(k*PRIV_WAYS+w);
        end
      end
    end
    insSlot = insHasFree ? insFreeSlot : insOldSlot;
  end

  // ---------------------------------------------------------------
  // Private directory next state. Ages are ranks: 0 = newest.
  always_comb begin
    pValidNxt = pValid;
    pTagNxt   = pTag;
    pShrNxt   = pShr;
    pAgeNxt   = pAge;
    for (int k = 0; k < NUM_CORES; k++) begin
      for (int w = 0; w < PRIV_WAYS; w++) begin
        if (remEn && PSLOT_W'(k*PRIV_WAYS+w) == pHitSlot)
          pValidNxt[k*PRIV_WAYS+w] = 1'b0;
        if (remEn && CORE_W'(k) == pHitBank && pValid[k*PRIV_WAYS+w]
            && pAge[k*PRIV_WAYS+w] > remAge)
          pAgeNxt[k*PRIV_WAYS+w] = pAgeNxt[k*PRIV_WAYS+w] - AGE_W'(1);
        if (insEn && CORE_W'(k) == insBank && validAfter[k*PRIV_WAYS+w]
            && PSLOT_W'(k*PRIV_WAYS+w) != insSlot)
          pAgeNxt[k*PRIV_WAYS+w] = pAgeNxt[k*PRIV_WAYS+w] + AGE_W'(1);
        if (insEn && PSLOT_W'(k*PRIV_WAYS+w) == insSlot) begin
          pValidNxt[k*PRIV_WAYS+w] = 1'b1;
          pTagNxt[k*PRIV_WAYS+w]   = insTag;
          pShrNxt[k*PRIV_WAYS+w]   = coreBit(insBank);
          pAgeNxt[k*PRIV_WAYS+w]   = '0;
        end
        if (isLocal && PSLOT_W'(k*PRIV_WAYS+w) == pHitSlot)
          pShrNxt[k*PRIV_WAYS+w] = pShr[k*PRIV_WAYS+w] | reqBit;
      end
    end
  end

  // Central directory next state
  always_comb begin
    sValidNxt = sValid;
    sTagNxt   = sTag;
    sShrNxt   = sShr;
    rrPtrNxt  = rrPtr;
    if (isShHit) sShrNxt[sHitSlot] = sShr[sHitSlot] | reqBit;
    if (isPromote) begin
      sValidNxt[sTgt] = 1'b1;
      sTagNxt[sTgt]   = curLine;
      sShrNxt[sTgt]   = pShr[pHitSlot] | reqBit;
    end
    if (needDemote)
      rrPtrNxt = (rrPtr == SH_W'(SHARED_SLOTS - 1)) ? '0 : rrPtr + SH_W'(1);
  end

  // ---------------------------------------------------------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pValid <= '0;
      sValid <= '0;
      rrPtr  <= '0;
      for (int i = 0; i < PRIV_SLOTS; i++) begin
        pTag[i] <= '0;
        pShr[i] <= '0;
        pAge[i] <= '0;
      end
      for (int j = 0; j < SHARED_SLOTS; j++) begin
        sTag[j] <= '0;
        sShr[j] <= '0;
      end
    end else if (strobe.commit) begin
      pValid <= pValidNxt;
      pTag   <= pTagNxt;
      pShr   <= pShrNxt;
      pAge   <= pAgeNxt;
      sValid <= sValidNxt;
      sTag   <= sTagNxt;
      sShr   <= sShrNxt;
      rrPtr  <= rrPtrNxt;
    end
  end

  // ---------------------------------------------------------------
  // Response, live during the commit cycle only
  always_comb begin
    rspBank      = '0;
    rspMigrate   = 1'b0;
    rspMigSrc    = '0;
    rspMigDst    = '0;
    rspDemote    = 1'b0;
    rspDemoteDst = '0;
    if (strobe.commit) begin
      rspBank = (isMiss || isLocal) ? BANK_W'(curCore) : SHARED_CODE;
      if (isPromote) begin
        rspMigrate = 1'b1;
        rspMigSrc  = BANK_W'(pHitBank);
        rspMigDst  = SHARED_CODE;
      end
      if (needDemote) begin
        rspDemote    = 1'b1;
        rspDemoteDst = BANK_W'(demoteCore);
      end
    end
  end

endmodule

// File: rtl/line_placement_ctl.sv
module line_placement_ctl
  import placement_pkg::*;
#(
  parameter int NUM_CORES    = 8,
  parameter int PRIV_WAYS    = 2,
  parameter int SHARED_SLOTS = 4,
  parameter int ADDR_W       = 12
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             reqValid,
  output logic                             reqReady,
  input  logic [$clog2(NUM_CORES)-1:0]     reqCore,
  input  logic [ADDR_W-1:0]                reqLine,
  output logic                             rspValid,
  output logic [$clog2(NUM_CORES+1)-1:0]   rspBank,
  output logic                             rspMigrate,
  output logic [$clog2(NUM_CORES+1)-1:0]   rspMigSrc,
  output logic [$clog2(NUM_CORES+1)-1:0]   rspMigDst,
  output logic                             rspDemote,
  output logic [$clog2(NUM_CORES+1)-1:0]   rspDemoteDst
);

  ctlStrobe_t strobe;

  placement_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  placement_datapath #(
    .NUM_CORES    (NUM_CORES),
    .PRIV_WAYS    (PRIV_WAYS),
    .SHARED_SLOTS (SHARED_SLOTS),
    .ADDR_W       (ADDR_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqCore      (reqCore),
    .reqLine      (reqLine),
    .rspBank      (rspBank),
    .rspMigrate   (rspMigrate),
    .rspMigSrc    (rspMigSrc),
    .rspMigDst    (rspMigDst),
    .rspDemote    (rspDemote),
    .rspDemoteDst (rspDemoteDst)
  );

endmodule

// File: rtl/line_placement_chk.sv
module line_placement_chk #(
  parameter int NUM_CORES    = 8,
  parameter int ADDR_W       = 12
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             reqValid,
  input logic                             reqReady,
  input logic [$clog2(NUM_CORES)-1:0]     reqCore,
  input logic [ADDR_W-1:0]                reqLine,
  input logic                             rspValid,
  input logic [$clog2(NUM_CORES+1)-1:0]   rspBank,
  input logic                             rspMigrate,
  input logic [$clog2(NUM_CORES+1)-1:0]   rspMigSrc,
  input logic [$clog2(NUM_CORES+1)-1:0]   rspMigDst,
  input logic                             rspDemote,
  input logic [$clog2(NUM_CORES+1)-1:0]   rspDemoteDst
);

  localparam int BANK_W = $clog2(NUM_CORES + 1);
  localparam logic [BANK_W-1:0] SHC = BANK_W'(NUM_CORES);

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);  // R9
  AST_RSP_HAS_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady));  // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);  // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspMigrate && !rspDemote));  // R9
  AST_PROMOTE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMigrate) |-> (rspBank == SHC && rspMigDst == SHC &&
      rspMigSrc < SHC && rspMigSrc != BANK_W'($past(reqCore))));  // R4
  AST_PRIVATE_IS_OWN: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspBank != SHC) |-> (rspBank == BANK_W'($past(reqCore)) && !rspMigrate));  // R2
  AST_DEMOTE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    rspDemote |-> (rspMigrate && rspDemoteDst < SHC));  // R7

endmodule

bind line_placement_ctl line_placement_chk #(
  .NUM_CORES (NUM_CORES),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqCore      (reqCore),
  .reqLine      (reqLine),
  .rspValid     (rspValid),
  .rspBank      (rspBank),
  .rspMigrate   (rspMigrate),
  .rspMigSrc    (rspMigSrc),
  .rspMigDst    (rspMigDst),
  .rspDemote    (rspDemote),
  .rspDemoteDst (rspDemoteDst)
);

// File: tb/sim_line_placement_ctl.sv
`timescale 1ns/1ps
module sim_line_placement_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int AW = 12;
  localparam int SH = NC;   // central bank code

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [2:0] reqCore = '0;
  logic [AW-1:0] reqLine = '0;
  logic       rspValid;
  logic [3:0] rspBank, rspMigSrc, rspMigDst, rspDemoteDst;
  logic       rspMigrate, rspDemote;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_placement_ctl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCore(reqCore), .reqLine(reqLine), .rspValid(rspValid),
    .rspBank(rspBank), .rspMigrate(rspMigrate), .rspMigSrc(rspMigSrc),
    .rspMigDst(rspMigDst), .rspDemote(rspDemote), .rspDemoteDst(rspDemoteDst)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // One access: drive at a falling edge, accepted at the next rising edge,
  // response sampled at the following falling edge.
  task automatic access(input int core, input int line, input int expBank,
                        input bit expMig, input int expSrc,
                        input bit expDem, input int expDemDst, input string req);
    reqCore  = 3'(core);
    reqLine  = AW'(line);
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid == 1'b1, "R9", "rspValid after accept", int'(rspValid), 1);
    check(reqReady == 1'b0, "R9", "reqReady while busy", int'(reqReady), 0);
    check(int'(rspBank) == expBank, req, $sformatf("bank core%0d line%0d", core, line),
          int'(rspBank), expBank);
    check(rspMigrate == expMig, req, $sformatf("migrate line%0d", line),
          int'(rspMigrate), int'(expMig));
    if (expMig) begin
      check(int'(rspMigSrc) == expSrc, req, "migrate source", int'(rspMigSrc), expSrc);
      check(int'(rspMigDst) == SH, req, "migrate destination", int'(rspMigDst), SH);
    end
    check(rspDemote == expDem, req, $sformatf("demote line%0d", line),
          int'(rspDemote), int'(expDem));
    if (expDem)
      check(int'(rspDemoteDst) == expDemDst, req, "demote destination",
            int'(rspDemoteDst), expDemDst);
    @(posedge clk);
    @(negedge clk);
    check(rspValid == 1'b0, "R9", "rspValid single cycle", int'(rspValid), 0);
    check(reqReady == 1'b1, "R9", "reqReady back", int'(reqReady), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: idle state right after reset
    check(reqReady == 1'b1, "R1", "reqReady after reset", int'(reqReady), 1);
    check(rspValid == 1'b0, "R1", "rspValid after reset", int'(rspValid), 0);

    // R2: first touches land in the requester's bank
    for (int k = 0; k < NC; k++) access(k, 100 + k, k, 0, 0, 0, 0, "R2");
    // R3: owners re-access their own lines
    for (int k = 0; k < NC; k++) access(k, 100 + k, k, 0, 0, 0, 0, "R3");

    // R4: promotion of 100 by a second core; R5: later sharers served centrally
    access(3, 100, SH, 1, 0, 0, 0, "R4");
    access(5, 100, SH, 0, 0, 0, 0, "R5");
    access(0, 100, SH, 0, 0, 0, 0, "R5");
    // R6: fill remaining central slots
    access(2, 101, SH, 1, 1, 0, 0, "R6");
    access(4, 102, SH, 1, 2, 0, 0, "R6");
    access(6, 103, SH, 1, 3, 0, 0, "R6");

    // R6/R7: central full, victim slot 0 (line 100, sharers 0,3,5) -> bank 0
    access(7, 104, SH, 1, 4, 1, 0, "R7");
    // R4 on the demoted line: owner now 0; victim slot 1 (101: 1,2) -> bank 1
    access(3, 100, SH, 1, 0, 1, 1, "R6");

    // R8: bank 1 holds 101 (older); add 200, then 201 evicts 101
    access(1, 200, 1, 0, 0, 0, 0, "R8");
    access(1, 201, 1, 0, 0, 0, 0, "R8");
    access(2, 101, 2, 0, 0, 0, 0, "R8");   // gone from cache: plain miss
    // 200 kept; victim slot 2 (102: 2,4) demoted into bank 2
    access(6, 200, SH, 1, 1, 1, 2, "R8");
    // bank 2 {101 old, 102}; 202 evicts 101
    access(2, 202, 2, 0, 0, 0, 0, "R8");
    // 102 still in bank 2; victim slot 3 (103: 3,6) -> bank 3
    access(7, 102, SH, 1, 2, 1, 3, "R6");
    access(7, 101, 7, 0, 0, 0, 0, "R8");

    // R6: pointer wrapped to slot 0 (104: 4,7) -> bank 4
    access(0, 105, SH, 1, 5, 1, 4, "R6");

    // R5: core 0 joins 200 (sharers 1,6); R7 then demotes it to core 0
    access(0, 200, SH, 0, 0, 0, 0, "R5");
    access(1, 106, SH, 1, 6, 1, 0, "R7");   // slot 1: 100 (0,3) -> bank 0
    access(2, 107, SH, 1, 7, 1, 0, "R5");   // slot 2: 200 (0,1,6) -> bank 0

    // R8 via demotion into a full bank: bank 2 {202 old, 203}
    access(2, 203, 2, 0, 0, 0, 0, "R8");
    access(5, 300, 5, 0, 0, 0, 0, "R2");
    access(4, 300, SH, 1, 5, 1, 2, "R8");   // slot 3: 102 (2,7) -> bank 2, drops 202
    access(3, 202, 3, 0, 0, 0, 0, "R8");
    access(2, 102, 2, 0, 0, 0, 0, "R3");

    // R1: reset clears the directory; central line 300 is a miss again
    doReset();
    check(reqReady == 1'b1, "R1", "reqReady after second reset", int'(reqReady), 1);
    access(0, 300, 0, 0, 0, 0, 0, "R1");
    access(6, 105, 6, 0, 0, 0, 0, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule